// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This block collects 36 interrupt sources (7 from pins outside the chip, 29 from on-chip logic) into two interrupt request lines for a processor: one critical and one non-critical. Each source is conditioned by its own trigger mode and polarity. Level sources follow their qualified input. Edge sources latch the active edge into a status bit that stays set until software clears it.

The status bits are ANDed with an enable register. Each source then goes to the critical or the non-critical line according to its own routing bit. Two identical controller instances are chained. The secondary takes 18 internal sources. The primary takes the 7 external and 11 internal sources, plus two extra inputs driven by the secondary's critical and non-critical requests. The primary always treats those two inputs as level-sensitive and active-high.

Software reaches both controllers through one plain register port. It writes in a single cycle, and reads combinationally from the selected controller. There is no streaming data path, so the port has no valid/ready handshake and never applies back-pressure.

Top module: `intc_cascade`

## Requirements
- R1: After reset, every status, enable, trigger-mode and routing bit is 0 and every polarity bit is 1. Both request outputs are low.
- R2: A source in level mode (trigger bit 0) shows its qualified input in its status bit one clock after the input is sampled. The qualified input is the input itself when the polarity bit is 1, and its inverse when the polarity bit is 0.
- R3: A source in edge mode (trigger bit 1) sets its status bit on a rising input when its polarity bit is 1, and on a falling input when its polarity bit is 0. The bit stays set after the input returns.
- R4: Writing the status register clears each edge-mode bit written with 1. Bits written with 0 and all level-mode bits are unchanged by the write.
- R5: If a clear of an edge-mode bit and a new active edge on that source fall in the same cycle, the bit ends up set.
- R6: The masked status reads as the bitwise AND of status and enable. When enable is all zero, both request outputs are low.
- R7: The critical output is high while any masked bit with routing bit 1 is set. The non-critical output is high while any masked bit with routing bit 0 is set.
- R8: An external input passes through two synchronizing flops. A change on it first shows in a level-mode status bit after the third rising clock edge.
- R9: Changing polarity never creates an edge event by itself. Edge detection works on the unqualified input history. No edge-mode status bit can be set in a cycle in which that controller's trigger or polarity register is written.
- R10: Primary input 18 carries the secondary's critical request and input 19 carries its non-critical request. These two inputs act as level, active-high regardless of the primary's trigger and polarity bits, and they follow the secondary's outputs one clock later.
- R11: Register map:
  - Select 0 picks the primary and select 1 picks the secondary.
  - Address 0 is status (write 1 to clear), 1 is enable, 2 is masked status (read only), 3 is trigger mode, 4 is polarity and 5 is routing.
  - Other addresses read 0, and bits above a controller's width read 0.
- R12: Source mapping:
  - External input k goes to primary bit k.
  - Internal input k goes to primary bit 7+k for k below 11.
  - Internal input k goes to secondary bit k-11 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_ext | input | 7 | External interrupt inputs, asynchronous |
| src_int | input | 29 | Internal interrupt inputs, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Controller select: 0 primary, 1 secondary |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq_crit | output | 1 | Critical interrupt request |
| irq_noncrit | output | 1 | Non-critical interrupt request |

## Verification
Two operations can fall in the same clock. The first pair is a software clear of an edge status bit and a fresh active edge on that same source. The bench raises an internal input in the very cycle that writes 1 to its status bit, and it expects the bit to read back set with the non-critical request high. The second pair is a trigger-register write and an active falling edge on an edge-mode source. There the status bit must stay clear, both on the next read and one cycle later.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_ENABLE = 3'd1,
    RA_MASKED = 3'd2,
    RA_TRIG   = 3'd3,
    RA_POL    = 3'd4,
    RA_ROUTE  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

  // cycles since reset, saturating at 2, so $past never reaches into reset
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/intc_cond.sv
module intc_cond #(
  parameter int W      = 20,
  parameter int CASC_W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr_mask,
  input  logic         cfg_wr,
  output logic [W-1:0] stat
);
  // bits forced to level, active-high (cascade inputs sit at the top)
  localparam logic [W-1:0] LVL_ONLY = ~({W{1'b1}} >> CASC_W);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= raw;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st_q;
    if (i >= W - CASC_W) begin : g_casc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= 1'b0;
        else        st_q <= raw[i];
      end
    end else begin : g_src
      logic qual;
      logic ev;
      assign qual = pol[i] ? raw[i] : ~raw[i];
      // event from the raw history: a polarity flip alone is no event
      assign ev   = pol[i] ? (raw[i] & ~prev_q[i]) : (~raw[i] & prev_q[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          st_q <= 1'b0;
        else if (edge_sel[i])
          st_q <= (st_q & ~clr_mask[i]) | (ev & ~cfg_wr);
        else
          st_q <= qual;
      end
    end
    assign stat[i] = st_q;
  end

  logic [W-1:0] edge_eff;
  logic [W-1:0] qual_v;
  assign edge_eff = edge_sel & ~LVL_ONLY;
  assign qual_v   = (raw & LVL_ONLY) | (~(raw ^ pol) & ~LVL_ONLY);

  p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((stat ^ $past(qual_v)) & ~$past(edge_eff)) == '0));

  p_edge_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat) & $past(edge_eff) & ~$past(clr_mask)) & ~stat) == '0));

  p_set_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && (|(clr_mask & edge_eff & raw & ~prev_q & pol)))
      |=> ((($past(clr_mask & edge_eff & raw & ~prev_q & pol)) & ~stat) == '0));

  p_no_cfg_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> ((stat & ~$past(stat) & $past(edge_eff)) == '0));
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int W      = 20,
  parameter int CASC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     src,
  input  logic             wr,
  input  logic [2:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             irq_crit,
  output logic             irq_nc
);
  logic [W-1:0] en_q, trig_q, pol_q, route_q;
  logic [W-1:0] stat, masked, clr_mask;
  logic         cfg_wr;

  assign clr_mask = (wr && addr == RA_STATUS) ? wdata[W-1:0] : '0;
  assign cfg_wr   = wr && (addr == RA_TRIG || addr == RA_POL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      trig_q  <= '0;
      pol_q   <= '1;
      route_q <= '0;
    end else if (wr) begin
      case (addr)
        RA_ENABLE: en_q    <= wdata[W-1:0];
        RA_TRIG:   trig_q  <= wdata[W-1:0];
        RA_POL:    pol_q   <= wdata[W-1:0];
        RA_ROUTE:  route_q <= wdata[W-1:0];
        default:   ;
      endcase
    end
  end

  intc_cond #(.W(W), .CASC_W(CASC_W)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (src),
    .edge_sel (trig_q),
    .pol      (pol_q),
    .clr_mask (clr_mask),
    .cfg_wr   (cfg_wr),
    .stat     (stat)
  );

  assign masked   = stat & en_q;
  assign irq_crit = |(masked & route_q);
  assign irq_nc   = |(masked & ~route_q);

  always_comb begin
    rdata = '0;
    case (addr)
      RA_STATUS: rdata[W-1:0] = stat;
      RA_ENABLE: rdata[W-1:0] = en_q;
      RA_MASKED: rdata[W-1:0] = masked;
      RA_TRIG:   rdata[W-1:0] = trig_q;
      RA_POL:    rdata[W-1:0] = pol_q;
      RA_ROUTE:  rdata[W-1:0] = route_q;
      default:   rdata = '0;
    endcase
  end

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_crit && !irq_nc));

  p_route_crit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit |-> (|(route_q & en_q)));

  if (CASC_W > 0) begin : g_casc_chk
    p_casc_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stat[W-1 -: CASC_W] == $past(src[W-1 -: CASC_W])));
  end
endmodule

// File: rtl/intc_cascade.sv
module intc_cascade
  import intc_pkg::*;
#(
  parameter int EXT_W = 7,
  parameter int INT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXT_W-1:0] src_ext,
  input  logic [INT_W-1:0] src_int,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_crit,
  output logic             irq_noncrit
);
  localparam int SRC_W   = EXT_W + INT_W;
  localparam int SEC_W   = SRC_W / 2;
  localparam int PRI_SRC = SRC_W - SEC_W;
  localparam int CASC_W  = 2;
  localparam int PRI_W   = PRI_SRC + CASC_W;

  logic [EXT_W-1:0] ext_sync;
  logic [SRC_W-1:0] src_all;
  logic [PRI_W-1:0] pri_src;
  logic [REG_W-1:0] pri_rd, sec_rd;
  logic             sec_crit, sec_nc;

  intc_sync #(.W(EXT_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (src_ext),
    .q     (ext_sync)
  );

  assign src_all = {src_int, ext_sync};
  assign pri_src = {sec_nc, sec_crit, src_all[PRI_SRC-1:0]};

  intc_core #(.W(SEC_W), .CASC_W(0)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src_all[SRC_W-1:PRI_SRC]),
    .wr       (reg_wr && reg_sel),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (sec_rd),
    .irq_crit (sec_crit),
    .irq_nc   (sec_nc)
  );

  intc_core #(.W(PRI_W), .CASC_W(CASC_W)) u_pri (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (pri_src),
    .wr       (reg_wr && !reg_sel),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (pri_rd),
    .irq_crit (irq_crit),
    .irq_nc   (irq_noncrit)
  );

  assign reg_rdata = reg_sel ? sec_rd : pri_rd;
endmodule

// File: tb/intc_cascade_bench.sv
`timescale 1ns/1ps
module intc_cascade_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  src_ext;
  logic [28:0] src_int;
  logic        reg_wr, reg_sel;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_crit, irq_noncrit;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  intc_cascade u_intc_cascade (
    .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .src_int(src_int),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_crit(irq_crit), .irq_noncrit(irq_noncrit)
  );

  typedef struct packed {
    logic        wr;
    logic        wsel;
    logic [2:0]  waddr;
    logic [31:0] wdata;
    logic [28:0] intv;
    logic        csel;
    logic [2:0]  caddr;
    logic [31:0] exp;
    logic        ecrit;
    logic        enc;
    logic [3:0]  req;
  } vec_t;

  // internal input 0 -> primary bit 7, 1 -> bit 8, 11 -> secondary bit 0 (R12)
  localparam vec_t VT [26] = '{
    '{1'b1,1'b0,3'd1,32'h180,  29'h0,  1'b0,3'd2,32'h0,    1'b0,1'b0,4'd6},  // R6 masked empty
    '{1'b0,1'b0,3'd0,32'h0,    29'h1,  1'b0,3'd0,32'h80,   1'b0,1'b1,4'd2},  // R2 level high
    '{1'b1,1'b0,3'd5,32'h80,   29'h1,  1'b0,3'd5,32'h80,   1'b1,1'b0,4'd7},  // R7 route crit
    '{1'b1,1'b0,3'd4,32'hFFF7F,29'h1,  1'b0,3'd4,32'hFFF7F,1'b1,1'b0,4'd11}, // R11 pol rw
    '{1'b0,1'b0,3'd0,32'h0,    29'h1,  1'b0,3'd0,32'h0,    1'b0,1'b0,4'd2},  // R2 active low
    '{1'b1,1'b0,3'd3,32'h100,  29'h1,  1'b0,3'd3,32'h100,  1'b0,1'b0,4'd11}, // R11 trig rw
    '{1'b0,1'b0,3'd0,32'h0,    29'h3,  1'b0,3'd0,32'h100,  1'b0,1'b1,4'd3},  // R3 rising
    '{1'b0,1'b0,3'd0,32'h0,    29'h1,  1'b0,3'd0,32'h100,  1'b0,1'b1,4'd3},  // R3 sticky
    '{1'b1,1'b0,3'd0,32'h80,   29'h1,  1'b0,3'd2,32'h100,  1'b0,1'b1,4'd4},  // R4 zero bit kept
    '{1'b1,1'b0,3'd0,32'h100,  29'h1,  1'b0,3'd0,32'h0,    1'b0,1'b0,4'd4},  // R4 clear
    '{1'b1,1'b0,3'd0,32'h100,  29'h3,  1'b0,3'd0,32'h100,  1'b0,1'b1,4'd5},  // R5 set wins
    '{1'b1,1'b0,3'd0,32'h100,  29'h3,  1'b0,3'd0,32'h0,    1'b0,1'b0,4'd4},  // R4 clear again
    '{1'b1,1'b0,3'd4,32'hFFE7F,29'h3,  1'b0,3'd0,32'h0,    1'b0,1'b0,4'd9},  // R9 pol flip
    '{1'b0,1'b0,3'd0,32'h0,    29'h1,  1'b0,3'd0,32'h100,  1'b0,1'b1,4'd3},  // R3 falling
    '{1'b1,1'b0,3'd0,32'h100,  29'h3,  1'b0,3'd0,32'h0,    1'b0,1'b0,4'd3},  // R3 inactive rise
    '{1'b1,1'b0,3'd3,32'h100,  29'h1,  1'b0,3'd0,32'h0,    1'b0,1'b0,4'd9},  // R9 cfg write
    '{1'b0,1'b0,3'd0,32'h0,    29'h1,  1'b0,3'd0,32'h0,    1'b0,1'b0,4'd9},  // R9 still clear
    '{1'b1,1'b1,3'd1,32'h1,    29'h1,  1'b1,3'd1,32'h1,    1'b0,1'b0,4'd11}, // R11 sec enable
    '{1'b0,1'b0,3'd0,32'h0,    29'h801,1'b1,3'd0,32'h1,    1'b0,1'b0,4'd12}, // R12 sec map
    '{1'b1,1'b0,3'd1,32'h80180,29'h801,1'b0,3'd0,32'h80000,1'b0,1'b1,4'd10}, // R10 nc cascade
    '{1'b1,1'b1,3'd5,32'h1,    29'h801,1'b0,3'd0,32'h80000,1'b0,1'b1,4'd10}, // R10 lag
    '{1'b0,1'b0,3'd0,32'h0,    29'h801,1'b0,3'd0,32'h40000,1'b0,1'b0,4'd10}, // R10 crit cascade
    '{1'b1,1'b0,3'd3,32'h40100,29'h801,1'b0,3'd0,32'h40000,1'b0,1'b0,4'd10}, // R10 trig ignored
    '{1'b0,1'b0,3'd0,32'h0,    29'h1,  1'b0,3'd0,32'h40000,1'b0,1'b0,4'd10}, // R10 one lag
    '{1'b0,1'b0,3'd0,32'h0,    29'h1,  1'b0,3'd0,32'h0,    1'b0,1'b0,4'd10}, // R10 level drop
    '{1'b0,1'b0,3'd0,32'h0,    29'h1,  1'b0,3'd7,32'h0,    1'b0,1'b0,4'd11}  // R11 unused addr
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic read_chk(input int req, input logic sel, input logic [2:0] a,
                          input logic [31:0] exp, input string what);
    reg_sel  = sel;
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp, what);
  endtask

  initial begin
    rst_n = 1'b0; src_ext = '0; src_int = '0;
    reg_wr = 1'b0; reg_sel = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    read_chk(1, 1'b0, 3'd0, 32'h0,     "pri status");
    read_chk(1, 1'b0, 3'd1, 32'h0,     "pri enable");
    read_chk(1, 1'b0, 3'd4, 32'hFFFFF, "pri polarity");
    read_chk(1, 1'b1, 3'd4, 32'h3FFFF, "sec polarity");
    read_chk(1, 1'b1, 3'd3, 32'h0,     "sec trigger");
    read_chk(1, 1'b0, 3'd5, 32'h0,     "pri route");
    check(1, {irq_crit, irq_noncrit}, 32'h0, "irqs");
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 26; i++) begin
      reg_wr = VT[i].wr; reg_sel = VT[i].wsel; reg_addr = VT[i].waddr;
      reg_wdata = VT[i].wdata; src_int = VT[i].intv;
      @(negedge clk);
      reg_wr = 1'b0;
      read_chk(int'(VT[i].req), VT[i].csel, VT[i].caddr, VT[i].exp, $sformatf("vec%0d rdata", i));
      check(int'(VT[i].req), {31'h0, irq_crit},    {31'h0, VT[i].ecrit}, $sformatf("vec%0d crit", i));
      check(int'(VT[i].req), {31'h0, irq_noncrit}, {31'h0, VT[i].enc},   $sformatf("vec%0d noncrit", i));
    end

    // R8: external input 0 -> primary bit 0, level, visible after third edge
    reg_wr = 1'b1; reg_sel = 1'b0; reg_addr = 3'd1; reg_wdata = 32'h80181;
    @(negedge clk);
    reg_wr = 1'b0;
    src_ext = 7'h01;
    @(negedge clk);
    read_chk(8, 1'b0, 3'd0, 32'h0, "ext after edge 1");
    @(negedge clk);
    read_chk(8, 1'b0, 3'd0, 32'h0, "ext after edge 2");
    @(negedge clk);
    read_chk(8, 1'b0, 3'd0, 32'h1, "ext after edge 3");
    check(8, {31'h0, irq_noncrit}, 32'h1, "ext noncrit");

    // R4: write-one to a level bit has no effect
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    read_chk(4, 1'b0, 3'd0, 32'h1, "level bit survives clear");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule